// File: doc/BRIEF.md
# Prioritized interrupt level evaluator

This block decides, at each instruction boundary, whether a pending interrupt must be taken. It looks at two request vectors, a software request word and an external status word, turns every set bit into a candidate priority level, folds the candidates into one final level, and builds a summary mask of every source bit it saw. When the final level beats the current priority level, it raises a one-cycle trap pulse and loads the summary and level into two holding registers that the trap handler reads.

Evaluation is gated by an internal pending flag. A strobe from outside sets it, reset sets it, and every evaluation clears it. No evaluation takes place while the processor runs in privileged mode or on the cycle it resumes an instruction whose fetch missed. In either case the pending flag survives for a later boundary.

Top module: `irq_level_eval`

## Requirements
- R1: A synchronous active-high reset clears `isum`, `iid` and `trap` and sets the pending flag, so the first unprivileged boundary after reset evaluates without a strobe.
- R2: An evaluation happens only in a cycle with `step`=1, pending flag set, `priv_mode`=0 and `miss_resume`=0; in any other cycle `trap` stays 0 and the pending flag is kept.
- R3: Each evaluation clears the pending flag, with or without a trap; `chk_set`=1 sets it for the next cycle and wins over a clear in the same cycle.
- R4: A set `sw_req` bit i, for i in 1..15, gives candidate level i-1+1 = i and sets bit i of the summary mask.
- R5: A set `ext_stat` bit i, for i in 16..31, gives candidate level i and sets bit i of the summary mask.
- R6: External sources are scanned after software sources, so any set external bit overrides every software candidate.
- R7: Within a scan the highest-numbered set bit decides the level.
- R8: A trap is taken only when the final level is nonzero and strictly greater than `cur_ipl`.
- R9: On a taken trap, `isum` gets the summary mask and `iid` gets the final level one clock after the evaluating edge; otherwise both hold their values.
- R10: `trap` is 1 for exactly the one cycle after the evaluating edge of each taken interrupt.
- R11: `sw_req` bits 0 and 16..31 and `ext_stat` bits 0..15 are ignored: they add no level and no summary bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Instruction boundary strobe |
| chk_set | input | 1 | Requests an evaluation at a later boundary |
| priv_mode | input | 1 | Privileged bit of the program counter; blocks evaluation |
| miss_resume | input | 1 | Resuming after a completed fetch miss; blocks evaluation |
| sw_req | input | 32 | Software interrupt request word |
| ext_stat | input | 32 | External interrupt status word |
| cur_ipl | input | 5 | Current priority level |
| isum | output | 32 | Summary mask of the last taken interrupt |
| iid | output | 5 | Level of the last taken interrupt |
| trap | output | 1 | One-cycle trap request |

## Verification
A pending flag stuck high shows as a second trap at the very next boundary without a strobe; one stuck low or lost in a blocked cycle shows as a missing pulse at the first unblocked boundary. A wrong scan order or level offset shows in `iid` and `isum` one clock after the evaluating edge, and a holding register that is loaded without a trap shows on the next cycle as a value changed while `trap` is 0. Since every cycle's outputs are compared against a model, any such fault surfaces within one clock of the stimulus that exposes it.

// File: rtl/irq_level_eval.sv
module irq_level_eval #(
  parameter int WORD_W    = 32,
  parameter int SW_FIRST  = 1,
  parameter int SW_LAST   = 15,
  parameter int EXT_FIRST = 16,
  parameter int EXT_LAST  = 31,
  parameter int LVL_W     = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              chk_set,
  input  logic              priv_mode,
  input  logic              miss_resume,
  input  logic [WORD_W-1:0] sw_req,
  input  logic [WORD_W-1:0] ext_stat,
  input  logic [LVL_W-1:0]  cur_ipl,
  output logic [WORD_W-1:0] isum,
  output logic [LVL_W-1:0]  iid,
  output logic              trap
);

  logic              pend;
  logic [LVL_W-1:0]  cand_lvl;
  logic [WORD_W-1:0] cand_mask;
  logic              eval;
  logic              take;

  // software scan first, external second; the last set bit found wins
  always_comb begin
    cand_lvl  = '0;
    cand_mask = '0;
    for (int i = SW_FIRST; i <= SW_LAST; i++) begin
      if (sw_req[i]) begin
        cand_lvl     = LVL_W'(i - SW_FIRST + 1);
        cand_mask[i] = 1'b1;
      end
    end
    for (int i = EXT_FIRST; i <= EXT_LAST; i++) begin
      if (ext_stat[i]) begin
        cand_lvl     = LVL_W'(i);
        cand_mask[i] = 1'b1;
      end
    end
  end

  assign eval = step && pend && !priv_mode && !miss_resume;
  assign take = eval && (cand_lvl != '0) && (cand_lvl > cur_ipl);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b1;
      isum <= '0;
      iid  <= '0;
      trap <= 1'b0;
    end else begin
      pend <= chk_set || (pend && !eval);
      trap <= take;
      if (take) begin
        isum <= cand_mask;
        iid  <= cand_lvl;
      end
    end
  end

  AST_TRAP_GATED: assert property (@(posedge clk) disable iff (rst)
    trap |-> $past(step && !priv_mode && !miss_resume)); // R2

  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
    trap |-> (pend == $past(chk_set))); // R3

  AST_EXT_BIT_SEEN: assert property (@(posedge clk) disable iff (rst)
    (trap && (int'(iid) >= EXT_FIRST)) |-> isum[iid]); // R5

  AST_ABOVE_IPL: assert property (@(posedge clk) disable iff (rst)
    trap |-> ((iid > $past(cur_ipl)) && (iid != '0))); // R8

  AST_HOLD_REGS: assert property (@(posedge clk) disable iff (rst)
    (!trap && !$past(rst)) |-> ($stable(isum) && $stable(iid))); // R9

endmodule

// File: tb/irq_level_eval_tb.sv
`timescale 1ns/1ps
module irq_level_eval_tb;

  typedef struct {
    logic        trap;
    logic [31:0] isum;
    logic [4:0]  iid;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0, chk_set = 1'b0, priv_mode = 1'b0, miss_resume = 1'b0;
  logic [31:0] sw_req = '0, ext_stat = '0;
  logic [4:0]  cur_ipl = '0;
  logic [31:0] isum;
  logic [4:0]  iid;
  logic        trap;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  exp_t q[$];

  logic        m_pend;
  logic [31:0] m_isum;
  logic [4:0]  m_iid;

  always #10 clk = ~clk;

  irq_level_eval u_dut (
    .clk(clk), .rst(rst), .step(step), .chk_set(chk_set),
    .priv_mode(priv_mode), .miss_resume(miss_resume),
    .sw_req(sw_req), .ext_stat(ext_stat), .cur_ipl(cur_ipl),
    .isum(isum), .iid(iid), .trap(trap)
  );

  function automatic logic [4:0] top_bit(input logic [31:0] v, input int lo, input int hi);
    logic [4:0] r = '0;
    for (int b = hi; b >= lo; b--) if (v[b] && r == '0) r = 5'(b);
    return r;
  endfunction

  task automatic cyc(input logic st, input logic ck, input logic pv, input logic mr,
                     input logic [31:0] sw, input logic [31:0] ex,
                     input logic [4:0] ipl, input string tag);
    exp_t e;
    logic ev, tk;
    logic [4:0] lvl;
    logic [31:0] msk;
    @(negedge clk);
    step = st; chk_set = ck; priv_mode = pv; miss_resume = mr;
    sw_req = sw; ext_stat = ex; cur_ipl = ipl;
    msk = {ex[31:16], sw[15:1], 1'b0};
    lvl = top_bit(ex, 16, 31);
    if (lvl == '0) lvl = top_bit(sw, 1, 15);
    ev = st && m_pend && !pv && !mr;
    tk = ev && lvl != '0 && lvl > ipl;
    m_pend = ck || (m_pend && !ev);
    if (tk) begin m_isum = msk; m_iid = lvl; end
    e.trap = tk; e.isum = m_isum; e.iid = m_iid; e.tag = tag;
    @(posedge clk); #1;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, tag);
  endtask

  task automatic strobe();
    cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, '0, "R3 strobe");
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        total++;
        if (trap !== e.trap || isum !== e.isum || iid !== e.iid) begin
          bad++;
          $display("FAIL %s: trap=%0b isum=%h iid=%0d expected trap=%0b isum=%h iid=%0d",
                   e.tag, trap, isum, iid, e.trap, e.isum, e.iid);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    m_pend = 1'b1; m_isum = '0; m_iid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (trap !== 1'b0 || isum !== '0 || iid !== '0) begin
      bad++;
      $display("FAIL R1 reset: trap=%0b isum=%h iid=%0d expected 0 0 0", trap, isum, iid);
    end
    rst = 1'b0;
    // R1: pending after reset, R4 software level
    cyc(1, 0, 0, 0, 32'h0000_0020, '0, 5'd0, "R1 R4 first eval after reset");
    idle("R10 pulse drops");
    // R3: no strobe -> nothing
    cyc(1, 0, 0, 0, 32'h0000_0040, '0, 5'd0, "R3 cleared pending");
    // R7 highest software bit
    strobe();
    cyc(1, 0, 0, 0, 32'h0000_0208, '0, 5'd0, "R7 highest sw bit");
    // R6 R5 external overrides
    strobe();
    cyc(1, 0, 0, 0, 32'h0000_0080, 32'h0012_0000, 5'd0, "R6 R5 ext overrides sw");
    // R2 privileged blocks, pending survives
    strobe();
    cyc(1, 0, 1, 0, '0, 32'h0200_0000, 5'd0, "R2 priv blocks");
    cyc(1, 0, 0, 0, '0, 32'h0200_0000, 5'd0, "R2 pending kept after priv");
    // R2 miss resume blocks
    strobe();
    cyc(1, 0, 0, 1, 32'h0000_0010, '0, 5'd0, "R2 miss resume blocks");
    cyc(1, 0, 0, 0, 32'h0000_0010, '0, 5'd0, "R2 pending kept after miss");
    // R8 equal level: no trap, pending cleared
    strobe();
    cyc(1, 0, 0, 0, '0, 32'h0004_0000, 5'd18, "R8 equal level no trap");
    cyc(1, 0, 0, 0, '0, 32'h0004_0000, 5'd17, "R3 R8 pending consumed");
    strobe();
    cyc(1, 0, 0, 0, '0, 32'h0004_0000, 5'd17, "R8 above level trap");
    // R11 ignored bits
    strobe();
    cyc(1, 0, 0, 0, 32'h0010_0001, 32'h0000_8009, 5'd0, "R11 ignored bits no trap");
    strobe();
    cyc(1, 0, 0, 0, 32'h0000_0005, 32'h8000_8001, 5'd0, "R11 R5 top ext bit");
    // R3 set wins over clear; R10 back to back pulses
    strobe();
    cyc(1, 1, 0, 0, 32'h0000_0002, '0, 5'd0, "R3 set wins, R10 first pulse");
    cyc(1, 0, 0, 0, 32'h0000_0004, '0, 5'd0, "R10 second pulse");
    idle("R10 no trap when idle");
    // R4 boundary and all ones
    strobe();
    cyc(1, 0, 0, 0, 32'h0000_8000, '0, 5'd14, "R4 top sw level");
    strobe();
    cyc(1, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd30, "R9 R11 all ones");
    strobe();
    cyc(1, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, "R8 R9 hold at max ipl");
    idle("R9 hold idle");
    idle("R9 hold idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule